// File: doc/BRIEF.md
# PCI Subtractive Decode Target

This block is a target-side agent on a 32-bit PCI bus that picks up transactions no other target wants. When a master starts a transaction, the agent stores the address and command. It then watches the shared DEVSEL# line for a fixed number of decode clocks. If any other target responds in that window, the agent stands back until the bus is idle again. If no target responds and the command and address fall within the legacy spaces it serves, the agent claims the cycle by driving DEVSEL# low.

A claimed cycle is passed to a slow downstream port as a level strobe. There are four strobes, for I/O read, I/O write, memory read and memory write, and each is active low. The strobe stays asserted until the downstream side returns an acknowledge. The agent then completes the single data phase with TRDY#, and for a read it drives the returned data onto AD. If the master still holds FRAME# low, the agent adds STOP# to disconnect. The agent also holds a run-time bit that switches subtractive claiming off. The agent takes the state of that bit only when a new address phase starts.

The target control lines DEVSEL#, TRDY# and STOP# share one output enable. After a transaction the agent drives all three high for one clock and then releases them.

Top module: `pci_sub_agent`

## Requirements
- R1: After reset `tgtOe` and `adOe` are 0, all four downstream strobes are high and the decode-off bit is clear, so the first eligible transaction is claimed.
- R2: The commands (C/BE#[3:0] during the address phase) 4'b0000, 4'b0001, 4'b1010 and 4'b1011 are never claimed. The reserved codes 4'b0100, 4'b0101, 4'b1000, 4'b1001 and the dual-address code 4'b1101 are not claimed either.
- R3: Take edge A as the first rising edge at which `frameN` is sampled low after being high. If `busDevselN` is high at edges A+1, A+2 and A+3, then `tgtOe`=1 and `devselN`=0 directly after edge A+3 and never earlier.
- R4: If `busDevselN` is sampled low at any of edges A+1 to A+3, the agent never drives the bus during that transaction. It stays idle until `frameN` and `irdyN` are both sampled high.
- R5: The I/O commands are 4'b0010 (read) and 4'b0011 (write). They are claimed only when AD[31:16] is zero at edge A.
- R6: The memory reads are 4'b0110, 4'b1100 and 4'b1110, and the memory writes are 4'b0111 and 4'b1111. They are claimed only when AD[31:20] is zero at edge A.
- R7: Once the agent has claimed, the first edge with `irdyN` low captures the write data and the byte enables (`ioBe` = ~C/BE#). From the next cycle exactly one strobe is low (`ioRdN`, `ioWrN`, `memRdN` or `memWrN`). `ioAddr` carries AD[19:0]. The strobe stays low until `ioAck` is sampled high, and no two strobes are ever low together.
- R8: `trdyN` stays high until `ioAck` has been sampled high. In the following cycle `trdyN` is 0. For a read, `adOe`=1 and `adOut` holds the `ioRdata` value sampled with the acknowledge.
- R9: `stopN` is 0 together with `trdyN` exactly when `frameN` was low at the edge that sampled `ioAck`.
- R10: After the data phase completes (`trdyN` and `irdyN` both low at an edge), `tgtOe` stays 1 for one cycle with `devselN`, `trdyN` and `stopN` all high. In the cycle after that, `tgtOe` is 0.
- R11: When `ctlWe` is high at an edge, that edge loads the decode-off bit from `ctlDisable`. While the bit is set at edge A, the transaction is not claimed. A write after edge A does not affect the transaction already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| frameN | input | 1 | FRAME# as seen on the bus |
| irdyN | input | 1 | IRDY# as seen on the bus |
| cbeN | input | 4 | Command / byte enables, active low |
| adIn | input | 32 | AD as seen on the bus |
| busDevselN | input | 1 | DEVSEL# from all other targets |
| adOut | output | 32 | Read data to AD |
| adOe | output | 1 | AD output enable |
| devselN | output | 1 | This agent's DEVSEL# |
| trdyN | output | 1 | This agent's TRDY# |
| stopN | output | 1 | This agent's STOP# |
| tgtOe | output | 1 | Enable for devselN/trdyN/stopN |
| ctlWe | input | 1 | Write strobe for the decode-off bit |
| ctlDisable | input | 1 | Value for the decode-off bit |
| ioAddr | output | 20 | Downstream address |
| ioWdata | output | 32 | Downstream write data |
| ioBe | output | 4 | Downstream byte enables, active high |
| ioRdN | output | 1 | I/O read strobe |
| ioWrN | output | 1 | I/O write strobe |
| memRdN | output | 1 | Memory read strobe |
| memWrN | output | 1 | Memory write strobe |
| ioAck | input | 1 | Downstream acknowledge |
| ioRdata | input | 32 | Downstream read data |

## Verification
The assertions assume that other targets never drive `busDevselN` low while this agent is claiming. They also assume that a master keeps `irdyN` low once it has asserted it, and that `frameN` stays high for at least one clock between transactions. The stimulus drives `busDevselN` low only inside the decode window of a cycle the agent is not claiming, and releases it together with FRAME# and IRDY#. It asserts IRDY# in the cycle after the address phase and holds it until turnaround, and it returns FRAME# and IRDY# high before every new address phase. The commands, addresses, acknowledge delays, other-target timings and decode-off writes are random and come from a fixed seed.

// File: rtl/pci_sub_pkg.sv
package pci_sub_pkg;

  localparam int AdW = 32;
  localparam int CbeW = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WATCH,
    ST_BACKOFF,
    ST_CLAIM,
    ST_XFER,
    ST_PRESENT,
    ST_TURN
  } agentState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchAddr;
    logic latchData;
    logic latchRead;
  } dpStrobes_t;

  localparam logic [3:0] CMD_IO_RD   = 4'b0010;
  localparam logic [3:0] CMD_IO_WR   = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
  localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
  localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

  function automatic logic isIoCmd(input logic [3:0] cmd);
    return (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);
  endfunction

  function automatic logic isMemCmd(input logic [3:0] cmd);
    return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR) || (cmd == CMD_MEM_RDM) ||
           (cmd == CMD_MEM_RDL) || (cmd == CMD_MEM_WRI);
  endfunction

endpackage

// File: rtl/pci_sub_datapath.sv
module pci_sub_datapath
  import pci_sub_pkg::*;
#(
  parameter int IoSpanBits  = 16,
  parameter int MemSpanBits = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobes_t             stb,
  input  logic [AdW-1:0]         adIn,
  input  logic [CbeW-1:0]        cbeN,
  input  logic                   frameN,
  input  logic [AdW-1:0]         ioRdata,
  output logic                   hitNow,
  output logic                   isWrite,
  output logic                   isIo,
  output logic                   stopQ,
  output logic [MemSpanBits-1:0] addrQ,
  output logic [AdW-1:0]         wdataQ,
  output logic [CbeW-1:0]        beQ,
  output logic [AdW-1:0]         rdataQ
);

  logic ioRange;
  logic memRange;

  // R5 / R6: range decode on the live address phase
  assign ioRange  = (adIn[AdW-1:IoSpanBits] == '0);
  assign memRange = (adIn[AdW-1:MemSpanBits] == '0);
  assign hitNow   = (isIoCmd(cbeN) && ioRange) || (isMemCmd(cbeN) && memRange);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isWrite <= 1'b0;
      isIo    <= 1'b0;
      addrQ   <= '0;
    end else if (stb.latchAddr) begin
      isWrite <= cbeN[0];
      isIo    <= (cbeN[3:1] == 3'b001);
      addrQ   <= adIn[MemSpanBits-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdataQ <= '0;
      beQ    <= '0;
    end else if (stb.latchData) begin
      wdataQ <= adIn;
      beQ    <= ~cbeN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
      stopQ  <= 1'b0;
    end else if (stb.latchRead) begin
      rdataQ <= ioRdata;
      stopQ  <= !frameN;
    end
  end

endmodule

// File: rtl/pci_sub_control.sv
module pci_sub_control
  import pci_sub_pkg::*;
#(
  parameter int WindowClks = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        busDevselN,
  input  logic        hitNow,
  input  logic        ioAck,
  input  logic        ctlWe,
  input  logic        ctlDisable,
  input  logic        stopQ,
  output dpStrobes_t  stb,
  output agentState_t stateQ,
  output logic        tgtOe,
  output logic        devselN,
  output logic        trdyN,
  output logic        stopN,
  output logic        strobeOn
);

  localparam int CntW = $clog2(WindowClks + 1);

  agentState_t stateD;
  logic [CntW-1:0] cntQ, cntD;
  logic prevFrameN;
  logic decodeOffQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) decodeOffQ <= 1'b0;
    else if (ctlWe) decodeOffQ <= ctlDisable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      cntQ       <= '0;
      prevFrameN <= 1'b1;
    end else begin
      stateQ     <= stateD;
      cntQ       <= cntD;
      prevFrameN <= frameN;
    end
  end

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    stb    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (!frameN && prevFrameN) begin
          stb.latchAddr = 1'b1;
          cntD          = CntW'(1);
          stateD        = (hitNow && !decodeOffQ) ? ST_WATCH : ST_BACKOFF;
        end
      end
      ST_WATCH: begin
        if (!busDevselN) stateD = ST_BACKOFF;
        else if (cntQ == CntW'(WindowClks)) stateD = ST_CLAIM;
        else cntD = cntQ + CntW'(1);
      end
      ST_BACKOFF: begin
        if (frameN && irdyN) stateD = ST_IDLE;
      end
      ST_CLAIM: begin
        if (!irdyN) begin
          stb.latchData = 1'b1;
          stateD        = ST_XFER;
        end
      end
      ST_XFER: begin
        if (ioAck) begin
          stb.latchRead = 1'b1;
          stateD        = ST_PRESENT;
        end
      end
      ST_PRESENT: begin
        if (!irdyN) stateD = ST_TURN;
      end
      ST_TURN: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    tgtOe    = (stateQ == ST_CLAIM) || (stateQ == ST_XFER) ||
               (stateQ == ST_PRESENT) || (stateQ == ST_TURN);
    devselN  = !((stateQ == ST_CLAIM) || (stateQ == ST_XFER) || (stateQ == ST_PRESENT));
    trdyN    = !(stateQ == ST_PRESENT);
    stopN    = !((stateQ == ST_PRESENT) && stopQ);
    strobeOn = (stateQ == ST_XFER);
  end

endmodule

// File: rtl/pci_sub_agent.sv
module pci_sub_agent
  import pci_sub_pkg::*;
#(
  parameter int WindowClks  = 3,
  parameter int IoSpanBits  = 16,
  parameter int MemSpanBits = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameN,
  input  logic                   irdyN,
  input  logic [3:0]             cbeN,
  input  logic [31:0]            adIn,
  input  logic                   busDevselN,
  output logic [31:0]            adOut,
  output logic                   adOe,
  output logic                   devselN,
  output logic                   trdyN,
  output logic                   stopN,
  output logic                   tgtOe,
  input  logic                   ctlWe,
  input  logic                   ctlDisable,
  output logic [MemSpanBits-1:0] ioAddr,
  output logic [31:0]            ioWdata,
  output logic [3:0]             ioBe,
  output logic                   ioRdN,
  output logic                   ioWrN,
  output logic                   memRdN,
  output logic                   memWrN,
  input  logic                   ioAck,
  input  logic [31:0]            ioRdata
);

  dpStrobes_t  stb;
  agentState_t stateQ;
  logic hitNow, isWrite, isIo, stopQ, strobeOn;
  logic [31:0] rdataQ;

  pci_sub_control #(.WindowClks(WindowClks)) uControl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
    .busDevselN(busDevselN), .hitNow(hitNow), .ioAck(ioAck),
    .ctlWe(ctlWe), .ctlDisable(ctlDisable), .stopQ(stopQ),
    .stb(stb), .stateQ(stateQ), .tgtOe(tgtOe), .devselN(devselN),
    .trdyN(trdyN), .stopN(stopN), .strobeOn(strobeOn)
  );

  pci_sub_datapath #(.IoSpanBits(IoSpanBits), .MemSpanBits(MemSpanBits)) uDatapath (
    .clk(clk), .rstN(rstN), .stb(stb), .adIn(adIn), .cbeN(cbeN),
    .frameN(frameN), .ioRdata(ioRdata), .hitNow(hitNow), .isWrite(isWrite),
    .isIo(isIo), .stopQ(stopQ), .addrQ(ioAddr), .wdataQ(ioWdata),
    .beQ(ioBe), .rdataQ(rdataQ)
  );

  assign ioRdN  = !(strobeOn && isIo && !isWrite);
  assign ioWrN  = !(strobeOn && isIo && isWrite);
  assign memRdN = !(strobeOn && !isIo && !isWrite);
  assign memWrN = !(strobeOn && !isIo && isWrite);

  assign adOe  = (stateQ == ST_PRESENT) && !isWrite;
  assign adOut = adOe ? rdataQ : '0;

endmodule

// File: rtl/pci_sub_checker.sv
module pci_sub_checker (
  input logic        clk,
  input logic        rstN,
  input logic        frameN,
  input logic        irdyN,
  input logic [3:0]  cbeN,
  input logic        busDevselN,
  input logic        devselN,
  input logic        trdyN,
  input logic        stopN,
  input logic        tgtOe,
  input logic        ioRdN,
  input logic        ioWrN,
  input logic        memRdN,
  input logic        memWrN,
  input logic        ioAck
);

  logic claimOn;
  logic anyStb;
  logic [3:0] stbVec;
  assign claimOn = tgtOe && !devselN;
  assign stbVec  = {!ioRdN, !ioWrN, !memRdN, !memWrN};
  assign anyStb  = |stbVec;

  assert_claim_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    (claimOn && !$past(claimOn)) |->
      ($past(busDevselN, 1) && $past(busDevselN, 2) && $past(busDevselN, 3) && !$past(frameN, 4)));

  assert_skip_special_R2: assert property (@(posedge clk) disable iff (!rstN)
    (claimOn && !$past(claimOn)) |->
      !($past(cbeN, 4) inside {4'b0000, 4'b0001, 4'b1010, 4'b1011}));

  assert_yield_other_R4: assert property (@(posedge clk) disable iff (!rstN)
    !busDevselN |-> !claimOn);

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbVec));

  assert_strobe_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (anyStb && !ioAck) |=> anyStb);

  assert_trdy_after_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tgtOe && !trdyN && !$past(tgtOe && !trdyN)) |-> $past(ioAck));

  assert_stop_with_trdy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tgtOe && !stopN) |-> !trdyN);

  assert_turnaround_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tgtOe && !trdyN && !irdyN) |=> (tgtOe && devselN && trdyN && stopN));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tgtOe && devselN) |=> !tgtOe);

endmodule

bind pci_sub_agent pci_sub_checker uChecker (
  .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cbeN(cbeN),
  .busDevselN(busDevselN), .devselN(devselN), .trdyN(trdyN), .stopN(stopN),
  .tgtOe(tgtOe), .ioRdN(ioRdN), .ioWrN(ioWrN), .memRdN(memRdN),
  .memWrN(memWrN), .ioAck(ioAck)
);

// File: tb/pci_sub_agent_test.sv
`timescale 1ns/1ps
module pci_sub_agent_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1, irdyN = 1'b1, busDevselN = 1'b1;
  logic [3:0] cbeN = 4'hF;
  logic [31:0] adIn = '0;
  logic [31:0] adOut;
  logic adOe, devselN, trdyN, stopN, tgtOe;
  logic ctlWe = 1'b0, ctlDisable = 1'b0;
  logic [19:0] ioAddr;
  logic [31:0] ioWdata;
  logic [3:0] ioBe;
  logic ioRdN, ioWrN, memRdN, memWrN;
  logic ioAck = 1'b0;
  logic [31:0] ioRdata = '0;

  int checks = 0;
  int fails = 0;
  bit offModel = 1'b0;

  always #4 clk = !clk;

  pci_sub_agent uut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cbeN(cbeN),
    .adIn(adIn), .busDevselN(busDevselN), .adOut(adOut), .adOe(adOe),
    .devselN(devselN), .trdyN(trdyN), .stopN(stopN), .tgtOe(tgtOe),
    .ctlWe(ctlWe), .ctlDisable(ctlDisable), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .ioBe(ioBe), .ioRdN(ioRdN), .ioWrN(ioWrN), .memRdN(memRdN), .memWrN(memWrN),
    .ioAck(ioAck), .ioRdata(ioRdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit expHit(input logic [3:0] cmd, input logic [31:0] addr);
    bit io, mem;
    io  = (cmd == 4'b0010 || cmd == 4'b0011) && (addr[31:16] == 16'h0);
    mem = (cmd inside {4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111}) && (addr[31:20] == 12'h0);
    return io || mem;
  endfunction

  function automatic logic [3:0] expStrobes(input logic [3:0] cmd);
    // order {ioRdN, ioWrN, memRdN, memWrN}
    if (cmd == 4'b0010) return 4'b0111;
    if (cmd == 4'b0011) return 4'b1011;
    if (cmd[0]) return 4'b1110;
    return 4'b1101;
  endfunction

  task automatic setOff(input bit v);
    ctlWe = 1'b1; ctlDisable = v;
    @(posedge clk); @(negedge clk);
    ctlWe = 1'b0;
    offModel = v;
  endtask

  task automatic doTxn(input logic [3:0] cmd, input logic [31:0] addr,
                       input logic [31:0] wdata, input logic [3:0] be,
                       input int otherAt, input bit hold, input int ackDelay,
                       input bit flip, input string tag);
    bit expClaim, wr;
    logic [31:0] rd;
    wr = cmd[0];
    expClaim = expHit(cmd, addr) && !offModel && (otherAt == 0);
    rd = $urandom;
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd;
    @(posedge clk); @(negedge clk);
    frameN = hold ? 1'b0 : 1'b1; irdyN = 1'b0; cbeN = ~be;
    adIn = wr ? wdata : $urandom;
    if (flip) begin ctlWe = 1'b1; ctlDisable = !offModel; end
    if (otherAt == 1) busDevselN = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk); @(negedge clk);
      ctlWe = 1'b0;
      if (otherAt == k + 1) busDevselN = 1'b0;
      if (k < 3) check(!tgtOe, "R3", {tag, " early drive"}, tgtOe, 0);
    end
    if (flip) offModel = !offModel;
    check((tgtOe && !devselN) == expClaim, expClaim ? "R3" : "R2/R4/R5/R6/R11",
          {tag, " claim"}, tgtOe && !devselN, expClaim);
    if (!expClaim) begin
      frameN = 1'b0;
      @(posedge clk); @(negedge clk);
      check(!tgtOe, "R4", {tag, " stays off bus"}, tgtOe, 0);
      frameN = 1'b1; irdyN = 1'b1; busDevselN = 1'b1;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      check(!tgtOe && ioRdN && ioWrN && memRdN && memWrN, "R4", {tag, " idle after"}, tgtOe, 0);
      return;
    end
    @(posedge clk); @(negedge clk);
    check({ioRdN, ioWrN, memRdN, memWrN} == expStrobes(cmd), "R7", {tag, " strobe"},
          {ioRdN, ioWrN, memRdN, memWrN}, expStrobes(cmd));
    check(ioAddr == addr[19:0], "R7", {tag, " address"}, ioAddr, addr[19:0]);
    check(ioBe == be, "R7", {tag, " byte enables"}, ioBe, be);
    if (wr) check(ioWdata == wdata, "R7", {tag, " write data"}, ioWdata, wdata);
    check(trdyN, "R8", {tag, " trdy before ack"}, trdyN, 1);
    for (int d = 0; d < ackDelay; d++) begin
      @(posedge clk); @(negedge clk);
      check({ioRdN, ioWrN, memRdN, memWrN} == expStrobes(cmd) && trdyN, "R7",
            {tag, " strobe held"}, {ioRdN, ioWrN, memRdN, memWrN}, expStrobes(cmd));
    end
    ioAck = 1'b1; ioRdata = rd;
    @(posedge clk); @(negedge clk);
    ioAck = 1'b0;
    check(!trdyN && !devselN && tgtOe, "R8", {tag, " trdy after ack"}, trdyN, 0);
    check({ioRdN, ioWrN, memRdN, memWrN} == 4'hF, "R7", {tag, " strobe off"},
          {ioRdN, ioWrN, memRdN, memWrN}, 4'hF);
    check(stopN == !hold, "R9", {tag, " stop"}, stopN, !hold);
    if (!wr) check(adOe && adOut == rd, "R8", {tag, " read data"}, adOut, rd);
    else check(!adOe, "R8", {tag, " no AD drive on write"}, adOe, 0);
    frameN = 1'b1;
    @(posedge clk); @(negedge clk);
    irdyN = 1'b1;
    check(tgtOe && devselN && trdyN && stopN && !adOe, "R10", {tag, " turnaround"},
          {tgtOe, devselN, trdyN, stopN}, 4'hF);
    @(posedge clk); @(negedge clk);
    check(!tgtOe, "R10", {tag, " release"}, tgtOe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check(!tgtOe && !adOe, "R1", "reset bus drive", {tgtOe, adOe}, 0);
    check({ioRdN, ioWrN, memRdN, memWrN} == 4'hF, "R1", "reset strobes",
          {ioRdN, ioWrN, memRdN, memWrN}, 4'hF);
    rstN = 1'b1;
    @(negedge clk);
    doTxn(4'b0011, 32'h0000_03F8, 32'hA5A5_0001, 4'b0001, 0, 0, 1, 0, "R1 R5 first io write");
    doTxn(4'b0010, 32'h0000_0060, 32'h0, 4'b1111, 0, 1, 3, 0, "R5 R9 io read hold");
    doTxn(4'b1010, 32'h0000_0010, 32'h0, 4'b1111, 0, 0, 0, 0, "R2 cfg read");
    doTxn(4'b1011, 32'h0000_0010, 32'h1, 4'b1111, 0, 0, 0, 0, "R2 cfg write");
    doTxn(4'b0000, 32'h0000_0000, 32'h0, 4'b1111, 0, 0, 0, 0, "R2 int ack");
    doTxn(4'b0001, 32'h0000_0000, 32'h0, 4'b1111, 0, 0, 0, 0, "R2 special");
    doTxn(4'b1101, 32'h0000_0000, 32'h0, 4'b1111, 0, 0, 0, 0, "R2 dual addr");
    doTxn(4'b0011, 32'h0000_0300, 32'h2, 4'b1111, 1, 0, 0, 0, "R4 fast other");
    doTxn(4'b0011, 32'h0000_0300, 32'h2, 4'b1111, 2, 0, 0, 0, "R4 medium other");
    doTxn(4'b0011, 32'h0000_0300, 32'h2, 4'b1111, 3, 0, 0, 0, "R4 slow other");
    doTxn(4'b0010, 32'h0001_0000, 32'h0, 4'b1111, 0, 0, 0, 0, "R5 io out of range");
    doTxn(4'b0010, 32'h0000_FFFF, 32'h0, 4'b1111, 0, 0, 0, 0, "R5 io top");
    doTxn(4'b0110, 32'h000F_FFFC, 32'h0, 4'b1111, 0, 0, 2, 0, "R6 mem read top");
    doTxn(4'b1111, 32'h0000_8000, 32'hDEAD_BEEF, 4'b0110, 0, 1, 0, 0, "R6 mem write inv");
    doTxn(4'b0111, 32'h0010_0000, 32'h3, 4'b1111, 0, 0, 0, 0, "R6 mem out of range");
    setOff(1'b1);
    doTxn(4'b0011, 32'h0000_0080, 32'h4, 4'b1111, 0, 0, 0, 0, "R11 disabled");
    doTxn(4'b0011, 32'h0000_0080, 32'h5, 4'b1111, 0, 0, 0, 1, "R11 enable mid");
    doTxn(4'b0011, 32'h0000_0080, 32'h6, 4'b1111, 0, 0, 0, 1, "R11 disable mid");
    doTxn(4'b0011, 32'h0000_0080, 32'h7, 4'b1111, 0, 0, 0, 0, "R11 now off");
    setOff(1'b0);
    for (int i = 0; i < 80; i++) begin
      logic [3:0] cmd;
      logic [31:0] addr;
      int r, other;
      cmd = 4'($urandom_range(0, 15));
      r = $urandom_range(0, 3);
      addr = $urandom;
      if (r == 1) addr = addr & 32'h0000_FFFF;
      else if (r == 2) addr = addr & 32'h000F_FFFF;
      r = $urandom_range(0, 7);
      other = (r < 3) ? r + 1 : 0;
      doTxn(cmd, addr, $urandom, 4'($urandom), other, $urandom_range(0, 3) == 0,
            $urandom_range(0, 4), $urandom_range(0, 7) == 0, "R3 R7 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule